// File: doc/BRIEF.md
# Voltage-Code Settle and Fault Blanking Unit

This unit sits between the 6-bit voltage-select code driven by a processor and the reference converter of a multiphase regulator. The raw code bits pass through a two-flop synchronizer. Any change in the synchronized code starts a settle window. While that window runs, the code held for the converter stays frozen, so bits that arrive with skew cannot produce a false setpoint. When the window expires with no further change, the unit captures the code and issues a one-cycle valid strobe. Each further change restarts the window. The code may step up or down, and a transition arrives as several codes in a row.

A second, longer window drives a blanking flag that keeps power-good and overvoltage-crowbar faults masked while a stepped transition runs. The first change of a sequence starts this window and every later change restarts it. Both window lengths are given in nanoseconds. They are converted to clock cycles from the clock frequency and rounded up, so the minimum times always hold. The blank window is meant to be at least as long as the settle window.

A four-state controller sequences the unit:
- BOOT waits for the synchronizer to fill.
- STEADY has no window open.
- SETTLE has the settle window running, with blanking active.
- TAIL has the code captured while blanking still runs.

Transitions:
- BOOT→STEADY once the synchronizer is full, loading the code directly.
- STEADY→SETTLE on a change.
- SETTLE→SETTLE on a change.
- SETTLE→TAIL on settle expiry while blanking continues.
- SETTLE→STEADY on settle expiry when blanking ends in the same cycle.
- TAIL→SETTLE on a change.
- TAIL→STEADY on blank expiry.

Top module: `vid_settle_blank`

## Requirements
- R1: After reset release, the held code equals the raw code that has been held steady since release. It loads at the third rising edge with no valid strobe, and blanking stays low.
- R2: A raw change applied between edges is seen as a change after two edges. The held code keeps its old value until edge S+3 after the change, where S is the settle length in cycles. It never changes without a valid strobe once boot is over.
- R3: The settle length S equals ceil(SETTLE_NS × CLK_HZ / 1e9) cycles. A non-integer product rounds up.
- R4: The valid strobe is high for exactly one cycle, in the cycle the held code updates. This holds even when the captured code equals the previous one.
- R5: A further change that is detected while the settle window runs (up to and including its last cycle) restarts the window. The code captured is then the last one.
- R6: Blanking rises at edge 3 after the first raw change. It is high whenever a settle window runs.
- R7: Blanking stays high without a gap until B cycles after the last detected change, falling at edge B+3 after the last raw change. A change during the tail restarts it.
- R8: Every one of the 64 codes is accepted, whether the step is upward or downward.
- R9: The blank length B equals ceil(BLANK_NS × CLK_HZ / 1e9) cycles, rounded up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_raw | input | 6 | Unsynchronized voltage-select code from the processor |
| vid_code | output | 6 | Settled code for the reference converter |
| vid_valid | output | 1 | One-cycle strobe when vid_code is captured |
| fault_blank | output | 1 | High while power-good and crowbar faults are to be masked |

## Verification
A wrong controller state or timer count shows at the ports as a held-code update or valid strobe landing on the wrong edge. It can also show as blanking that falls early or leaves a gap. The bench pins each of these to the exact edge, counted from the raw change, and compares on every cycle of every window. A fault therefore shows within one window length (at most B+4 cycles) of the stimulus that exposes it.

// File: rtl/vid_pkg.sv
package vid_pkg;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_STEADY = 2'd1,
        ST_SETTLE = 2'd2,
        ST_TAIL   = 2'd3
    } vid_state_t;

    // Convert a time in ns to clock cycles, rounding up, at least one.
    function automatic int ns_to_cycles(input longint ns, input longint hz);
        longint prod;
        longint cyc;
        prod = ns * hz;
        cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        if (cyc < 1) cyc = 1;
        return int'(cyc);
    endfunction

endpackage

// File: rtl/vid_sync.sv
module vid_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else begin
                    if (s == 0) stage_q[s] <= din;
                    else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/vid_change_det.sv
module vid_change_det #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [WIDTH-1:0] cur,
    output logic             changed
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur;
    end

    assign changed = enable && (cur != prev_q);
endmodule

// File: rtl/vid_retrig_timer.sv
module vid_retrig_timer #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start)        cnt_q <= CW'(LEN);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1)) && !start;
endmodule

// File: rtl/vid_settle_blank.sv
module vid_settle_blank #(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned SETTLE_NS = 400,
    parameter int unsigned BLANK_NS  = 100_000,
    parameter int          CODE_W    = 6,
    parameter int          SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] vid_raw,
    output logic [CODE_W-1:0] vid_code,
    output logic              vid_valid,
    output logic              fault_blank
);
    import vid_pkg::*;

    localparam int SETTLE_CYC = ns_to_cycles(longint'(SETTLE_NS), longint'(CLK_HZ));
    localparam int BLANK_CYC  = ns_to_cycles(longint'(BLANK_NS), longint'(CLK_HZ));
    localparam int BOOT_W     = $clog2(SYNC_STG + 1);

    logic [CODE_W-1:0] sync_code;
    logic              chg;
    logic              settle_busy, settle_done;
    logic              blank_busy, blank_done;
    logic [BOOT_W-1:0] boot_cnt_q;
    logic              boot_done;

    vid_state_t state_q, state_d;

    vid_sync #(.WIDTH(CODE_W), .STAGES(SYNC_STG)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(vid_raw), .dout(sync_code)
    );

    vid_change_det #(.WIDTH(CODE_W)) det_i (
        .clk(clk), .rst_n(rst_n), .enable(state_q != ST_BOOT),
        .cur(sync_code), .changed(chg)
    );

    vid_retrig_timer #(.LEN(SETTLE_CYC)) settle_tmr_i (
        .clk(clk), .rst_n(rst_n), .start(chg),
        .busy(settle_busy), .done(settle_done)
    );

    vid_retrig_timer #(.LEN(BLANK_CYC)) blank_tmr_i (
        .clk(clk), .rst_n(rst_n), .start(chg),
        .busy(blank_busy), .done(blank_done)
    );

    // Boot counter: waits for the synchronizer to fill.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             boot_cnt_q <= '0;
        else if (state_q == ST_BOOT && !boot_done) boot_cnt_q <= boot_cnt_q + 1'b1;
    end
    assign boot_done = (boot_cnt_q == BOOT_W'(SYNC_STG));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:   if (boot_done) state_d = ST_STEADY;
            ST_STEADY: if (chg)       state_d = ST_SETTLE;
            ST_SETTLE: begin
                if (chg)
                    state_d = ST_SETTLE;
                else if (settle_done)
                    state_d = (blank_busy && !blank_done) ? ST_TAIL : ST_STEADY;
            end
            ST_TAIL: begin
                if (chg)             state_d = ST_SETTLE;
                else if (blank_done) state_d = ST_STEADY;
            end
            default:   state_d = ST_BOOT;
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vid_code  <= '0;
            vid_valid <= 1'b0;
        end else begin
            vid_valid <= 1'b0;
            if (state_q == ST_BOOT && boot_done) begin
                vid_code <= sync_code;
            end else if (state_q == ST_SETTLE && settle_done) begin
                vid_code  <= sync_code;
                vid_valid <= 1'b1;
            end
        end
    end

    assign fault_blank = blank_busy;

    // settle_busy is implied by state SETTLE; kept visible for the checker
    logic unused_ok;
    assign unused_ok = settle_busy;

endmodule

// File: rtl/vid_settle_blank_chk.sv
module vid_settle_blank_chk #(
    parameter int CODE_W = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CODE_W-1:0]   code,
    input logic                valid,
    input logic                blank,
    input logic                settle_busy,
    input vid_pkg::vid_state_t state
);
    import vid_pkg::*;

    assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    assert_code_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_BOOT && !valid) |-> $stable(code));

    assert_valid_after_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (state == ST_STEADY || state == ST_TAIL));

    assert_blank_in_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |-> (blank && settle_busy));

    assert_no_blank_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STEADY) |-> !blank);

    assert_boot_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BOOT) |-> (!blank && !valid));
endmodule

bind vid_settle_blank vid_settle_blank_chk #(.CODE_W(CODE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .code(vid_code), .valid(vid_valid),
    .blank(fault_blank), .settle_busy(settle_busy), .state(state_q)
);

// File: tb/vid_settle_blank_tb_top.sv
module vid_settle_blank_tb_top;
    localparam int S = 5;   // settle cycles for both instances
    localparam int B = 20;  // blank cycles for both instances

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] raw = 6'h2C;
    logic [5:0] code_a, code_b;
    logic       valid_a, valid_b, blank_a, blank_b;
    int         total = 0;
    int         bad = 0;
    logic [5:0] cur;

    always #5 clk = ~clk;

    // exact products: 50 ns and 200 ns at 100 MHz
    vid_settle_blank #(.CLK_HZ(100_000_000), .SETTLE_NS(50), .BLANK_NS(200)) dut_i (
        .clk(clk), .rst_n(rst_n), .vid_raw(raw),
        .vid_code(code_a), .vid_valid(valid_a), .fault_blank(blank_a));

    // non-integer products that must round up to the same counts
    vid_settle_blank #(.CLK_HZ(100_000_000), .SETTLE_NS(41), .BLANK_NS(191)) dut_round_i (
        .clk(clk), .rst_n(rst_n), .vid_raw(raw),
        .vid_code(code_b), .vid_valid(valid_b), .fault_blank(blank_b));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string req, input logic [5:0] ec,
                           input logic ev, input logic eb);
        chk({req, " code"},  code_a,  ec);
        chk({req, " valid"}, valid_a, ev);
        chk({req, " blank"}, blank_a, eb);
        chk("R3 rounded code",  code_b,  ec);
        chk("R3 rounded valid", valid_b, ev);
        chk("R9 rounded blank", blank_b, eb);
    endtask

    // One change, tracked until everything is quiet (R2 R4 R6 R7 R8).
    task automatic single(input logic [5:0] nxt);
        logic [5:0] old;
        old = cur;
        raw = nxt;
        for (int n = 1; n <= B + 4; n++) begin
            @(negedge clk);
            chk_all("R2 R8 single", (n >= S + 3) ? nxt : old,
                    (n == S + 3), (n >= 3 && n <= B + 2));
        end
        cur = nxt;
    endtask

    // Two changes g cycles apart (R5 R7). g must be <= S or >= S+3.
    task automatic pair(input logic [5:0] a, input logic [5:0] b, input int g);
        logic [5:0] old;
        old = cur;
        raw = a;
        for (int n = 1; n <= g; n++) begin
            @(negedge clk);
            chk_all("R5 first step", (n >= S + 3) ? a : old,
                    (n == S + 3), (n >= 3));
        end
        raw = b;
        for (int n = 1; n <= B + 4; n++) begin
            @(negedge clk);
            chk_all("R5 R7 second step",
                    (n >= S + 3) ? b : ((g >= S + 3) ? a : old),
                    (n == S + 3), ((g + n >= 3) && (n <= B + 2)));
        end
        cur = b;
    endtask

    initial begin
        // R1: boot load with code held steady across reset release
        cur = 6'h2C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int n = 1; n <= 3; n++) begin
            @(negedge clk);
            chk("R1 valid", valid_a, 0);
            chk("R1 blank", blank_a, 0);
        end
        chk("R1 boot code", code_a, 6'h2C);
        chk("R1 rounded boot code", code_b, 6'h2C);
        repeat (4) @(negedge clk);
        chk_all("R1 quiet", 6'h2C, 1'b0, 1'b0);

        // R8: visit all 64 codes, stepping both up and down
        for (int k = 1; k <= 64; k++) single(6'((k * 37 + 44) % 64));

        // R5: retrigger inside the settle window, including its last cycle
        for (int g = 1; g <= S; g++)
            pair(cur ^ 6'h15, cur ^ 6'h15 ^ 6'((g % 63) + 1), g);
        // R7: second change during the tail keeps blanking unbroken
        for (int g = S + 3; g < B; g++)
            pair(cur ^ 6'h0B, cur ^ 6'h0B ^ 6'((g % 63) + 1), g);
        // R4: glitch back to the original code still strobes once
        pair(cur ^ 6'h21, cur, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200_000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule